// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches a free-running 64-bit system counter supplied from outside and escalates in two steps when software stops servicing it. After a refresh, the block stores a deadline equal to the counter value plus a programmed offset. If the counter reaches that deadline with no further refresh, the first-stage output (meant as an interrupt) goes high and a new deadline one offset later is stored. If that second deadline also passes, the second-stage output (meant as a reset request) goes high and stays high until reset.

Software uses one single-cycle read/write port with a frame-select bit. The service frame holds only the kick word. The control frame holds the control/status word, the offset (32 or 48 bits, chosen by a version parameter), the 64-bit deadline, which software can read to work out time left, and an identity word. The identity word also appears in the service frame. Writing the control word always counts as a refresh. Writing the offset counts as a refresh only while the timer runs.

The sequencing is a four-state machine. IDLE means disabled. ARMED means running with no stage reached. ALERT means the first stage was reached. TRIPPED means the second stage was reached. The transitions are as follows. A control write with bit 0 set goes to ARMED from any state, and one with bit 0 clear goes to IDLE. A refresh while running returns ALERT or TRIPPED to ARMED. An expiry moves ARMED to ALERT and ALERT to TRIPPED. Every other case holds the state. The second-stage flag is a separate sticky bit set on the ALERT-to-TRIPPED move.

Top module: `two_stage_wdt`

## Requirements
- R1: After reset the timer is disabled, both stage outputs are low, and the control word, offset words and deadline words all read 0.
- R2: A write of any data to service-frame address 0x000 is a refresh. A refresh sets the deadline to the counter value of that cycle plus the offset and clears the first stage from the next cycle on.
- R3: A write to control-frame address 0x000 is a refresh, and its bit 0 becomes the enable. Reading that address gives enable in bit 0, the first-stage flag in bit 1 and the second-stage flag in bit 2. Writes to bits 1 and 2 have no effect. While disabled, no stage is ever reached.
- R4: A write to the offset (control-frame 0x008 or 0x00C) is a refresh only while enabled. The refresh uses the newly written offset. While disabled, such a write leaves the deadline unchanged.
- R5: When enabled, with the first stage clear and the counter at or beyond the deadline, the first-stage output rises one clock later and the deadline becomes the counter plus the offset.
- R6: When enabled, with the first stage set and the counter at or beyond the deadline, the second-stage output rises one clock later. It then stays high through refreshes and disabling until reset.
- R7: With version 1, the offset is 48 bits. Bits [31:0] are at 0x008 and bits [47:32] are bits [15:0] of 0x00C. Bits [31:16] of 0x00C read 0 and ignore writes.
- R8: The deadline reads as low word at 0x010 and high word at 0x014. Writing these words changes the deadline without a refresh, and such a write wins over a stage reload in the same cycle.
- R9: Address 0xFCC in either frame reads the version in bits [19:16] and 0 elsewhere (0x0001_0000 for version 1).
- R10: A refresh in the same cycle as an expiry wins: no stage is reached and the deadline is reloaded.
- R11: Unmapped addresses read 0 and writes to them change no register. In the service frame only 0x000 and 0xFCC are mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_cnt | input | 64 | Free-running system counter value |
| bus_en | input | 1 | Access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_frame | input | 1 | 0 = control frame, 1 = service frame |
| bus_addr | input | 12 | Byte address inside the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| ws0_irq | output | 1 | First-stage signal |
| ws1_rst | output | 1 | Second-stage signal (sticky) |

## Verification
A wrong state register or a wrong deadline shows at the stage outputs exactly one clock after the counter crosses the deadline the requirements predict, and the checks compare both outputs every cycle. Errors in the offset or deadline registers also show at once on the read port, because the bench reads the deadline words and the control word at random and compares them with its own model. Any wrong priority between refresh, expiry and deadline writes shifts a later expiry and is caught within one offset period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_ALERT   = 2'd2,
        ST_TRIPPED = 2'd3
    } wdt_state_e;

    // control frame word addresses
    localparam int unsigned A_CTRL   = 32'h000;
    localparam int unsigned A_OFF_LO = 32'h008;
    localparam int unsigned A_OFF_HI = 32'h00C;
    localparam int unsigned A_CMP_LO = 32'h010;
    localparam int unsigned A_CMP_HI = 32'h014;
    // service frame
    localparam int unsigned A_KICK   = 32'h000;
    // both frames
    localparam int unsigned A_IDENT  = 32'hFCC;

    localparam int unsigned IDENT_SHIFT = 16;

    function automatic int unsigned offset_width(input int unsigned ver);
        return (ver == 0) ? 32 : 48;
    endfunction

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
    import wdt_pkg::*;
#(
    parameter int unsigned VERSION = 1,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned CNT_W   = 64
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              enabled,
    input  logic              ws0,
    input  logic              ws1,
    input  logic [CNT_W-1:0]  off_q,
    input  logic [CNT_W-1:0]  cmp_q,
    output logic              wr_kick,
    output logic              wr_ctrl,
    output logic              wr_off_lo,
    output logic              wr_off_hi,
    output logic              wr_cmp_lo,
    output logic              wr_cmp_hi,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] IDENT_WORD = DATA_W'((VERSION & 32'hF) << IDENT_SHIFT);

    logic wr_any;
    logic in_ctrl;

    assign wr_any  = bus_en & bus_we;
    assign in_ctrl = ~bus_frame;

    assign wr_kick   = wr_any & bus_frame & (bus_addr == ADDR_W'(A_KICK));
    assign wr_ctrl   = wr_any & in_ctrl & (bus_addr == ADDR_W'(A_CTRL));
    assign wr_off_lo = wr_any & in_ctrl & (bus_addr == ADDR_W'(A_OFF_LO));
    assign wr_off_hi = wr_any & in_ctrl & (bus_addr == ADDR_W'(A_OFF_HI));
    assign wr_cmp_lo = wr_any & in_ctrl & (bus_addr == ADDR_W'(A_CMP_LO));
    assign wr_cmp_hi = wr_any & in_ctrl & (bus_addr == ADDR_W'(A_CMP_HI));

    always_comb begin
        rdata = '0;
        if (bus_frame) begin
            if (bus_addr == ADDR_W'(A_IDENT)) begin
                rdata = IDENT_WORD;
            end
        end else begin
            case (bus_addr)
                ADDR_W'(A_CTRL):   rdata = DATA_W'({ws1, ws0, enabled});
                ADDR_W'(A_OFF_LO): rdata = off_q[DATA_W-1:0];
                ADDR_W'(A_OFF_HI): rdata = off_q[2*DATA_W-1:DATA_W];
                ADDR_W'(A_CMP_LO): rdata = cmp_q[DATA_W-1:0];
                ADDR_W'(A_CMP_HI): rdata = cmp_q[2*DATA_W-1:DATA_W];
                ADDR_W'(A_IDENT):  rdata = IDENT_WORD;
                default:           rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_offset_reg.sv
module wdt_offset_reg
    import wdt_pkg::*;
#(
    parameter int unsigned VERSION = 1,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned CNT_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  off_q,
    output logic [CNT_W-1:0]  off_next
);

    localparam int unsigned OFF_W = offset_width(VERSION);

    logic [OFF_W-1:0] off_r;
    logic [OFF_W-1:0] off_nx;

    generate
        if (OFF_W > DATA_W) begin : g_wide
            always_comb begin
                off_nx = off_r;
                if (wr_lo) begin
                    off_nx[DATA_W-1:0] = wdata;
                end
                if (wr_hi) begin
                    off_nx[OFF_W-1:DATA_W] = wdata[OFF_W-DATA_W-1:0];
                end
            end
        end else begin : g_narrow
            always_comb begin
                off_nx = off_r;
                if (wr_lo) begin
                    off_nx = wdata[OFF_W-1:0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_r <= '0;
        end else begin
            off_r <= off_nx;
        end
    end

    assign off_q    = {{(CNT_W-OFF_W){1'b0}}, off_r};
    assign off_next = {{(CNT_W-OFF_W){1'b0}}, off_nx};

endmodule

// File: rtl/wdt_compare.sv
module wdt_compare #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_cnt,
    input  logic [CNT_W-1:0]  off_next,
    input  logic              refresh,
    input  logic              stage_load,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              reached
);

    logic [CNT_W-1:0] reload_val;

    assign reload_val = sys_cnt + off_next;
    assign reached    = (sys_cnt >= cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (refresh) begin
            cmp_q <= reload_val;
        end else if (wr_lo) begin
            cmp_q[DATA_W-1:0] <= wdata;
        end else if (wr_hi) begin
            cmp_q[CNT_W-1:DATA_W] <= wdata;
        end else if (stage_load) begin
            cmp_q <= reload_val;
        end
    end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_en_bit,
    input  logic refresh,
    input  logic reached,
    output logic enabled,
    output logic ws0,
    output logic ws1,
    output logic stage_load
);

    wdt_state_e state_q;
    wdt_state_e state_d;
    logic       expire;
    logic       ws1_q;
    logic       ws1_set;

    always_comb begin
        expire     = reached & ~refresh & (state_q != ST_IDLE);
        state_d    = state_q;
        stage_load = 1'b0;
        ws1_set    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_IDLE;
            end
            ST_ARMED: begin
                if (expire) begin
                    state_d    = ST_ALERT;
                    stage_load = 1'b1;
                end
            end
            ST_ALERT: begin
                if (expire) begin
                    state_d = ST_TRIPPED;
                    ws1_set = 1'b1;
                end
            end
            ST_TRIPPED: begin
                state_d = ST_TRIPPED;
            end
        endcase
        if (ctrl_wr) begin
            state_d = ctrl_en_bit ? ST_ARMED : ST_IDLE;
        end else if (refresh && (state_q != ST_IDLE)) begin
            state_d = ST_ARMED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ws1_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ws1_set) begin
                ws1_q <= 1'b1;
            end
        end
    end

    always_comb begin
        enabled = (state_q != ST_IDLE);
        ws0     = (state_q == ST_ALERT) || (state_q == ST_TRIPPED);
        ws1     = ws1_q;
    end

endmodule

// File: rtl/two_stage_wdt.sv
module two_stage_wdt
    import wdt_pkg::*;
#(
    parameter int unsigned VERSION = 1,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned CNT_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_cnt,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ws0_irq,
    output logic              ws1_rst
);

    logic             wr_kick, wr_ctrl, wr_off_lo, wr_off_hi, wr_cmp_lo, wr_cmp_hi;
    logic             enabled, ws0, ws1, stage_load, reached, refresh;
    logic [CNT_W-1:0] off_q, off_next, cmp_q;

    assign refresh = wr_kick | wr_ctrl | ((wr_off_lo | wr_off_hi) & enabled);

    wdt_bus_decode #(
        .VERSION(VERSION), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_dec (
        .bus_en(bus_en), .bus_we(bus_we), .bus_frame(bus_frame), .bus_addr(bus_addr),
        .enabled(enabled), .ws0(ws0), .ws1(ws1), .off_q(off_q), .cmp_q(cmp_q),
        .wr_kick(wr_kick), .wr_ctrl(wr_ctrl), .wr_off_lo(wr_off_lo), .wr_off_hi(wr_off_hi),
        .wr_cmp_lo(wr_cmp_lo), .wr_cmp_hi(wr_cmp_hi), .rdata(bus_rdata)
    );

    wdt_offset_reg #(
        .VERSION(VERSION), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_off (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_off_lo), .wr_hi(wr_off_hi),
        .wdata(bus_wdata), .off_q(off_q), .off_next(off_next)
    );

    wdt_compare #(
        .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .off_next(off_next),
        .refresh(refresh), .stage_load(stage_load), .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi),
        .wdata(bus_wdata), .cmp_q(cmp_q), .reached(reached)
    );

    wdt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_ctrl), .ctrl_en_bit(bus_wdata[0]),
        .refresh(refresh), .reached(reached), .enabled(enabled), .ws0(ws0), .ws1(ws1),
        .stage_load(stage_load)
    );

    assign ws0_irq = ws0;
    assign ws1_rst = ws1;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int unsigned CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] sys_cnt,
    input logic             ws0,
    input logic             ws1,
    input logic             enabled,
    input logic             refresh,
    input logic [CNT_W-1:0] cmp_q,
    input logic [CNT_W-1:0] off_next
);

    assert_ws1_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ws1 |=> ws1);

    assert_ws1_after_ws0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ws1) |-> $past(ws0));

    assert_no_fire_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ws0) |-> $past(enabled));

    assert_refresh_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> !ws0);

    assert_refresh_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (cmp_q == $past(sys_cnt) + $past(off_next)));

    assert_stage_needs_deadline_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ws0) |-> ($past(sys_cnt) >= $past(cmp_q)));

endmodule

bind two_stage_wdt wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .ws0(ws0_irq), .ws1(ws1_rst),
    .enabled(enabled), .refresh(refresh), .cmp_q(cmp_q), .off_next(off_next)
);

// File: tb/two_stage_wdt_test.sv
module two_stage_wdt_test;

    localparam int CLK_PERIOD = 10;
    localparam int VER = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_cnt = 64'd0;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_frame = 1'b0;
    logic [11:0] bus_addr = 12'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        ws0_irq, ws1_rst;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit          m_en, m_ws0, m_ws1;
    logic [63:0] m_cmp, m_off;
    logic [63:0] cnt = 64'h0000_0001_FFFF_FF00;
    int          step = 1;
    logic [31:0] last_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    two_stage_wdt #(.VERSION(VER)) uut (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .bus_en(bus_en), .bus_we(bus_we),
        .bus_frame(bus_frame), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ws0_irq(ws0_irq), .ws1_rst(ws1_rst)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input bit frame, input logic [11:0] a);
        if (frame) return (a == 12'hFCC) ? 32'(VER << 16) : 32'd0;
        case (a)
            12'h000: return {29'd0, m_ws1, m_ws0, m_en};
            12'h008: return m_off[31:0];
            12'h00C: return m_off[63:32];
            12'h010: return m_cmp[31:0];
            12'h014: return m_cmp[63:32];
            12'hFCC: return 32'(VER << 16);
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_step(input bit en, input bit we, input bit frame,
                              input logic [11:0] a, input logic [31:0] wd);
        bit wr, c_wr, kick, olo, ohi, clo, chi, refr, tmo;
        logic [63:0] n_off, n_cmp;
        wr   = en & we;
        c_wr = wr && !frame && a == 12'h000;
        kick = wr && frame && a == 12'h000;
        olo  = wr && !frame && a == 12'h008;
        ohi  = wr && !frame && a == 12'h00C;
        clo  = wr && !frame && a == 12'h010;
        chi  = wr && !frame && a == 12'h014;
        n_off = m_off;
        if (olo) n_off[31:0] = wd;
        if (ohi) n_off[47:32] = wd[15:0];
        refr = kick || c_wr || ((olo || ohi) && m_en);
        tmo  = m_en && !refr && (cnt >= m_cmp);
        n_cmp = m_cmp;
        if (refr) n_cmp = cnt + n_off;
        else if (clo) n_cmp[31:0] = wd;
        else if (chi) n_cmp[63:32] = wd;
        else if (tmo && !m_ws0) n_cmp = cnt + n_off;
        if (tmo) begin
            if (!m_ws0) m_ws0 = 1'b1;
            else m_ws1 = 1'b1;
        end
        if (refr) m_ws0 = 1'b0;
        if (c_wr) m_en = wd[0];
        m_off = n_off;
        m_cmp = n_cmp;
    endtask

    // one clock: check stage outputs, advance counter, drive an access
    task automatic cyc(input bit en, input bit we, input bit frame,
                       input logic [11:0] a, input logic [31:0] wd, input string tag);
        @(negedge clk);
        chk("R5 stage-1 output", {63'd0, ws0_irq}, {63'd0, m_ws0});
        chk("R6 stage-2 output", {63'd0, ws1_rst}, {63'd0, m_ws1});
        cnt = cnt + 64'(step);
        sys_cnt = cnt;
        bus_en = en; bus_we = we; bus_frame = frame; bus_addr = a; bus_wdata = wd;
        if (en && !we) begin
            #1;
            last_rd = bus_rdata;
            chk(tag, {32'd0, bus_rdata}, {32'd0, exp_read(frame, a)});
        end
        model_step(en, we, frame, a, wd);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 12'h0, 32'h0, "idle");
    endtask

    task automatic wr(input bit frame, input logic [11:0] a, input logic [31:0] wd);
        cyc(1'b1, 1'b1, frame, a, wd, "write");
    endtask

    task automatic rd(input bit frame, input logic [11:0] a, input string tag);
        cyc(1'b1, 1'b0, frame, a, 32'h0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240));
        m_en = 0; m_ws0 = 0; m_ws1 = 0; m_cmp = 0; m_off = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 12'h000, "R1 control after reset");
        chk("R1 control zero", {32'd0, last_rd}, 64'd0);
        rd(0, 12'h008, "R1 offset lo after reset");
        rd(0, 12'h014, "R1 deadline hi after reset");
        chk("R1 deadline zero", {32'd0, last_rd}, 64'd0);

        // R9 identity in both frames
        rd(0, 12'hFCC, "R9 identity control frame");
        chk("R9 identity value", {32'd0, last_rd}, 64'h0001_0000);
        rd(1, 12'hFCC, "R9 identity service frame");
        chk("R9 identity value service", {32'd0, last_rd}, 64'h0001_0000);

        // R7 upper offset bits ignored; R4 no refresh while disabled
        wr(0, 12'h00C, 32'hFFFF_FFFF);
        rd(0, 12'h00C, "R7 offset hi readback");
        chk("R7 offset hi masked", {32'd0, last_rd}, 64'h0000_FFFF);
        rd(0, 12'h010, "R4 deadline after disabled offset write");
        chk("R4 deadline unchanged", {32'd0, last_rd}, 64'd0);
        wr(0, 12'h00C, 32'h0);

        // R11 unmapped locations
        wr(0, 12'h020, 32'hDEAD_BEEF);
        rd(0, 12'h020, "R11 unmapped control read");
        rd(1, 12'h008, "R11 unmapped service read");
        chk("R11 service hole zero", {32'd0, last_rd}, 64'd0);

        // R3 status bits not writable, disabled never fires
        wr(0, 12'h000, 32'h0000_0006);
        rd(0, 12'h000, "R3 status write ignored");
        chk("R3 control reads zero", {32'd0, last_rd}, 64'd0);
        idle(30);
        chk("R3 no stage while disabled", {63'd0, ws0_irq}, 64'd0);

        // R5/R6 exact escalation timing with offset 10
        wr(0, 12'h008, 32'd10);
        wr(0, 12'h000, 32'h1);
        n = 0;
        while (!ws0_irq && n < 100) begin idle(1); n++; end
        chk("R5 cycles to stage 1", 64'(n), 64'd11);
        n = 0;
        while (!ws1_rst && n < 100) begin idle(1); n++; end
        chk("R6 cycles to stage 2", 64'(n), 64'd10);

        // R6 sticky through refresh and disable
        wr(1, 12'h000, 32'h0);
        idle(1);
        chk("R2 kick clears stage 1", {63'd0, ws0_irq}, 64'd0);
        chk("R6 stage 2 held after kick", {63'd0, ws1_rst}, 64'd1);
        wr(0, 12'h000, 32'h0);
        idle(1);
        chk("R6 stage 2 held after disable", {63'd0, ws1_rst}, 64'd1);

        // R10 refresh on the expiry cycle wins
        wr(0, 12'h008, 32'd5);
        wr(0, 12'h000, 32'h1);
        idle(4);
        wr(1, 12'h000, 32'h1234_5678);
        idle(1);
        chk("R10 refresh beats expiry", {63'd0, ws0_irq}, 64'd0);
        idle(8);

        // R8 deadline writes
        wr(0, 12'h014, cnt[63:32]);
        wr(0, 12'h010, cnt[31:0] + 32'd40);
        rd(0, 12'h010, "R8 deadline lo readback");
        rd(0, 12'h014, "R8 deadline hi readback");
        idle(50);

        // R7 wide offset readback
        wr(0, 12'h00C, 32'h0000_00A5);
        rd(0, 12'h00C, "R7 offset hi value");
        chk("R7 offset hi stored", {32'd0, last_rd}, 64'h0000_00A5);
        wr(0, 12'h00C, 32'h0);
        wr(0, 12'h000, 32'h1);

        // random mix
        for (int i = 0; i < 5000; i++) begin
            int op;
            logic [31:0] r;
            op = int'($urandom % 20);
            r = $urandom;
            step = (($urandom % 8) == 0) ? int'($urandom % 3) : 1;
            case (op)
                0, 1: wr(1, 12'h000, r);
                2: wr(0, 12'h000, {r[31:1], (r[3:2] != 2'b00)});
                3: wr(0, 12'h008, 32'd2 + (r % 40));
                4: wr(0, 12'h00C, r & 32'hFFFF_0000);
                5: rd(0, 12'h000, "R3 random control read");
                6: rd(0, 12'h010, "R8 random deadline lo read");
                7: rd(0, 12'h014, "R8 random deadline hi read");
                8: rd(0, 12'h008, "R7 random offset read");
                9: if (r[4:0] == 0) wr(0, 12'h010, cnt[31:0] + (r % 32)); else idle(1);
                10: wr(0, 12'h030, r);
                default: idle(1);
            endcase
        end
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule